// File: doc/BRIEF.md
# Reset Qualifier and Power Mode Controller

This block turns a raw, possibly noisy external reset pin into a clean synchronous core reset, and steers the clock enables of the core through its low-power modes. A free-running divider splits the oscillator clock into machine cycles of six states, each state two oscillator periods long. The reset pin passes through a two-flop synchronizer and is looked at once per machine cycle, at the second phase of the fifth state. The core reset is raised only after two consecutive looks see it high, so short glitches have no effect.

The power control register (eight bits, written by the CPU) holds two mode bits: bit 0 requests idle and bit 1 requests power-down. In idle only the CPU clock enable drops; peripherals, the interrupt logic and the oscillator keep running, and a pending interrupt or a reset brings the core back. In power-down every enable drops, the oscillator included, and only a reset leaves it. While the core reset is high the block presents the load values for the I/O ports (all ones) and the stack pointer (seven), and clears every register bit except bit 4. The serial data buffer is not part of the reset load.

The controller is a four-state machine. States: RESET (core reset held), RUN (normal execution), IDLE (CPU clock stopped), PDOWN (all clocks stopped). Transitions: any state to RESET on a qualified reset; RESET to RUN on the first low look at the pin; RUN to PDOWN when bit 1 is set (this wins when both bits are set); RUN to IDLE when only bit 0 is set; IDLE to RUN on a pending interrupt, clearing bit 0; PDOWN stays put until reset.

Top module: `reset_power_ctrl`

## Requirements
- R1: A machine cycle is 12 clock periods; the synchronized pin is looked at on one fixed clock of each cycle, the pin reaches that look two clocks after it changes, and `core_rst` rises one clock after the second consecutive look that sees the pin high.
- R2: A high pulse on `rst_pin` shorter than 12 clocks never raises `core_rst`.
- R3: `core_rst` falls one clock after the first look that sees the pin low.
- R4: While `core_rst` is high, `port_rst_val` is 0xFF, `sp_rst_val` is 0x07, `pcon_q` has every bit except bit 4 clear, bit 4 keeps its value, and all three clock enables are high.
- R5: A write to `pcon_q` (bit 0 = idle request, bit 1 = power-down request) takes effect on the clock it is strobed, only in RUN; writes in IDLE or PDOWN leave `pcon_q` unchanged. The mode is entered one clock after the write.
- R6: In IDLE, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R7: In IDLE, `irq_pending` high at a clock returns the block to RUN on that clock and clears bit 0 of `pcon_q`.
- R8: In PDOWN all three enables are 0; writing both mode bits at once enters PDOWN.
- R9: In PDOWN, `irq_pending` and register writes have no effect; only a qualified reset leaves it.
- R10: A qualified reset also ends IDLE and returns to RUN with both mode bits clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock, always running |
| rst_pin | input | 1 | Raw external reset pin, active high, asynchronous |
| pcon_we | input | 1 | Write strobe for the power control register |
| pcon_wdata | input | 8 | Write data for the power control register |
| irq_pending | input | 1 | An enabled interrupt is pending |
| core_rst | output | 1 | Qualified synchronous core reset, also the load strobe for reset values |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt logic clock enable |
| osc_en | output | 1 | Oscillator enable |
| pcon_q | output | 8 | Current power control register value |
| port_rst_val | output | 8 | Value loaded into the I/O ports on reset |
| sp_rst_val | output | 8 | Value loaded into the stack pointer on reset |

## Verification
The bench learns the phase of the machine-cycle look from the clock at which the first reset is released (that look lies one clock earlier), then predicts every later look as a multiple of 12 clocks from it. A pin rise driven before clock A is first seen by the look at or after A+2; `core_rst` is due one clock after the next look, and the bench samples it low on the clock before and high on the due clock, and does the same for the release. Register writes show in `pcon_q` right after the strobing clock, and the mode enables change one clock later, so each is sampled on its own falling edge; interrupt wake-up is due on the clock that samples `irq_pending`. Glitch rejection is checked by watching `core_rst` over a long window after pulses of 1, 6 and 11 clocks.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_IDLE  = 2'd2,
        ST_PDOWN = 2'd3
    } pmode_t;

    localparam int PCON_W   = 8;
    localparam int IDLE_BIT = 0;
    localparam int PD_BIT   = 1;
    localparam int KEEP_BIT = 4;
    localparam logic [PCON_W-1:0] KEEP_MASK = PCON_W'(1) << KEEP_BIT;

endpackage

// File: rtl/rpc_mc_timer.sv
module rpc_mc_timer #(
    parameter int STATES_PER_MC    = 6,
    parameter int PHASES_PER_STATE = 2,
    parameter int SAMPLE_STATE     = 5,
    parameter int SAMPLE_PHASE     = 2
) (
    input  logic clk,
    output logic sample_stb
);
    localparam int TICKS       = STATES_PER_MC * PHASES_PER_STATE;
    localparam int SAMPLE_TICK = (SAMPLE_STATE - 1) * PHASES_PER_STATE + (SAMPLE_PHASE - 1);
    localparam int CW          = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (tick_q >= CW'(TICKS - 1))
            tick_q <= '0;
        else
            tick_q <= tick_q + 1'b1;
    end

    assign sample_stb = (tick_q == CW'(SAMPLE_TICK));

    // R1: the phase counter never leaves the machine cycle
    always_comb begin
        assert_tick_range_R1: assert (tick_q < CW'(TICKS));
    end

endmodule

// File: rtl/rpc_rst_qual.sv
module rpc_rst_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_MC     = 2
) (
    input  logic clk,
    input  logic pin,
    input  logic sample_stb,
    output logic rst_req
);
    localparam int HW = $clog2(QUAL_MC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HW-1:0]          high_cnt_q;
    logic                   pin_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) sync_q <= pin;
        end else begin : g_chain
            always_ff @(posedge clk) sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
        end
    endgenerate

    assign pin_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (sample_stb) begin
            if (!pin_s)
                high_cnt_q <= '0;
            else if (high_cnt_q != HW'(QUAL_MC))
                high_cnt_q <= high_cnt_q + 1'b1;
        end
    end

    assign rst_req = (high_cnt_q == HW'(QUAL_MC));

    // R2: the qualification count moves only on a look at the pin
    assert_cnt_only_on_look_R2: assert property (@(posedge clk) disable iff (rst_req)
        !sample_stb |=> $stable(high_cnt_q));

endmodule

// File: rtl/rpc_pwr_fsm.sv
module rpc_pwr_fsm
    import rpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_req,
    input  logic              pcon_we,
    input  logic [PCON_W-1:0] pcon_wdata,
    input  logic              irq_pending,
    output logic              core_rst,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_en,
    output logic [PCON_W-1:0] pcon_q
);
    pmode_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_RUN;
            ST_RUN: begin
                if (pcon_q[PD_BIT])        state_d = ST_PDOWN;
                else if (pcon_q[IDLE_BIT]) state_d = ST_IDLE;
            end
            ST_IDLE:  if (irq_pending) state_d = ST_RUN;
            ST_PDOWN: state_d = ST_PDOWN;
        endcase
        if (rst_req) state_d = ST_RESET;
    end

    // state register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // power control register
    always_ff @(posedge clk) begin
        if (rst_req || state_q == ST_RESET)
            pcon_q <= pcon_q & KEEP_MASK;
        else if (state_q == ST_RUN && pcon_we)
            pcon_q <= pcon_wdata;
        else if (state_q == ST_IDLE && irq_pending)
            pcon_q[IDLE_BIT] <= 1'b0;
    end

    // outputs
    always_comb begin
        core_rst   = 1'b0;
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
        osc_en     = 1'b1;
        unique case (state_q)
            ST_RESET: core_rst = 1'b1;
            ST_RUN:   ;
            ST_IDLE:  cpu_clk_en = 1'b0;
            ST_PDOWN: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
                osc_en     = 1'b0;
            end
        endcase
    end

    // R4: register bits other than the kept one are clear during reset
    assert_reset_clears_pcon_R4: assert property (@(posedge clk)
        core_rst |-> ((pcon_q & ~KEEP_MASK) == '0));

    // R7: an interrupt in idle restarts the CPU and drops the idle bit
    assert_idle_wake_R7: assert property (@(posedge clk) disable iff (core_rst)
        (!cpu_clk_en && per_clk_en && irq_pending && !rst_req)
        |=> (cpu_clk_en && !pcon_q[IDLE_BIT]));

    // R8: the power-down bit wins over the idle bit
    assert_pd_priority_R8: assert property (@(posedge clk) disable iff (core_rst)
        (cpu_clk_en && pcon_q[PD_BIT] && !rst_req) |=> (!osc_en && !per_clk_en));

    // R9: power-down holds until a qualified reset
    assert_pd_exit_only_reset_R9: assert property (@(posedge clk) disable iff (core_rst)
        (!osc_en && !rst_req) |=> (!osc_en && $stable(pcon_q)));

endmodule

// File: rtl/reset_power_ctrl.sv
module reset_power_ctrl
    import rpc_pkg::*;
#(
    parameter int                STATES_PER_MC    = 6,
    parameter int                PHASES_PER_STATE = 2,
    parameter int                SAMPLE_STATE     = 5,
    parameter int                SAMPLE_PHASE     = 2,
    parameter int                SYNC_STAGES      = 2,
    parameter int                QUAL_MC          = 2,
    parameter logic [7:0]        PORT_INIT        = 8'hFF,
    parameter logic [7:0]        SP_INIT          = 8'h07
) (
    input  logic              clk_osc,
    input  logic              rst_pin,
    input  logic              pcon_we,
    input  logic [PCON_W-1:0] pcon_wdata,
    input  logic              irq_pending,
    output logic              core_rst,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_en,
    output logic [PCON_W-1:0] pcon_q,
    output logic [7:0]        port_rst_val,
    output logic [7:0]        sp_rst_val
);
    logic sample_stb;
    logic rst_req;

    rpc_mc_timer #(
        .STATES_PER_MC    (STATES_PER_MC),
        .PHASES_PER_STATE (PHASES_PER_STATE),
        .SAMPLE_STATE     (SAMPLE_STATE),
        .SAMPLE_PHASE     (SAMPLE_PHASE)
    ) u_timer (
        .clk        (clk_osc),
        .sample_stb (sample_stb)
    );

    rpc_rst_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_MC     (QUAL_MC)
    ) u_qual (
        .clk        (clk_osc),
        .pin        (rst_pin),
        .sample_stb (sample_stb),
        .rst_req    (rst_req)
    );

    rpc_pwr_fsm u_fsm (
        .clk         (clk_osc),
        .rst_req     (rst_req),
        .pcon_we     (pcon_we),
        .pcon_wdata  (pcon_wdata),
        .irq_pending (irq_pending),
        .core_rst    (core_rst),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .osc_en      (osc_en),
        .pcon_q      (pcon_q)
    );

    assign port_rst_val = PORT_INIT;
    assign sp_rst_val   = SP_INIT;

endmodule

// File: tb/reset_power_ctrl_bench.sv
`timescale 1ns/1ps
module reset_power_ctrl_bench;

    logic       clk_osc = 1'b0;
    logic       rst_pin = 1'b1;
    logic       pcon_we = 1'b0;
    logic [7:0] pcon_wdata = 8'h00;
    logic       irq_pending = 1'b0;
    logic       core_rst, cpu_clk_en, per_clk_en, osc_en;
    logic [7:0] pcon_q, port_rst_val, sp_rst_val;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tref = 0;
    bit done = 0;

    always #4 clk_osc = ~clk_osc;
    always @(posedge clk_osc) cyc <= cyc + 1;

    reset_power_ctrl u_reset_power_ctrl (
        .clk_osc      (clk_osc),
        .rst_pin      (rst_pin),
        .pcon_we      (pcon_we),
        .pcon_wdata   (pcon_wdata),
        .irq_pending  (irq_pending),
        .core_rst     (core_rst),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .osc_en       (osc_en),
        .pcon_q       (pcon_q),
        .port_rst_val (port_rst_val),
        .sp_rst_val   (sp_rst_val)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk_osc);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_osc);
    endtask

    // first look at or after clock e, looks are 12 clocks apart (R1)
    function automatic int next_look(input int e);
        int d;
        d = (e - tref) % 12;
        return (d == 0) ? e : e + 12 - d;
    endfunction

    task automatic pwrite(input logic [7:0] d);
        @(negedge clk_osc);
        pcon_we = 1'b1;
        pcon_wdata = d;
        @(negedge clk_osc);
        pcon_we = 1'b0;
    endtask

    task automatic hold_reset_then_release();
        rst_pin = 1'b1;
        for (int i = 0; i < 40 && !core_rst; i++) @(negedge clk_osc);
        idle_cycles(3);
    endtask

    task automatic wait_release();
        rst_pin = 1'b0;
        for (int i = 0; i < 40 && core_rst; i++) @(negedge clk_osc);
    endtask

    task automatic t_power_up();
        idle_cycles(40);
        chk("R4", "core_rst held", core_rst, 1);
        chk("R4", "port value", port_rst_val, 8'hFF);
        chk("R4", "sp value", sp_rst_val, 8'h07);
        chk("R4", "pcon cleared", pcon_q & 8'hEF, 0);
        chk("R4", "enables in reset", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
        wait_release();
        chk("R3", "released", core_rst, 0);
        tref = cyc - 1;
        chk("R3", "running after release", cpu_clk_en, 1);
    endtask

    task automatic t_glitch();
        int widths[3] = '{1, 6, 11};
        foreach (widths[j]) begin
            logic seen;
            seen = 1'b0;
            idle_cycles(5);
            rst_pin = 1'b1;
            for (int i = 0; i < widths[j]; i++) begin
                @(negedge clk_osc);
                seen |= core_rst;
            end
            rst_pin = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk_osc);
                seen |= core_rst;
            end
            chk("R2", $sformatf("glitch width %0d", widths[j]), seen, 0);
        end
    endtask

    task automatic t_exact(input int offset);
        int k, t2, t;
        idle_cycles(offset + 1);
        k = cyc;
        rst_pin = 1'b1;
        t2 = next_look(k + 3) + 12;
        wait_to(t2);
        chk("R1", "reset not yet", core_rst, 0);
        wait_to(t2 + 1);
        chk("R1", "reset due", core_rst, 1);
        idle_cycles(15);
        k = cyc;
        rst_pin = 1'b0;
        t = next_look(k + 3);
        wait_to(t);
        chk("R3", "still in reset", core_rst, 1);
        wait_to(t + 1);
        chk("R3", "release due", core_rst, 0);
    endtask

    task automatic t_idle();
        pwrite(8'h01);
        chk("R5", "write visible", pcon_q, 8'h01);
        chk("R5", "mode one clock later", cpu_clk_en, 1);
        @(negedge clk_osc);
        chk("R6", "idle enables", {cpu_clk_en, per_clk_en, osc_en}, 3'b011);
        pwrite(8'h02);
        idle_cycles(2);
        chk("R5", "write ignored in idle", pcon_q, 8'h01);
        chk("R6", "still idle", {cpu_clk_en, per_clk_en, osc_en}, 3'b011);
        irq_pending = 1'b1;
        @(negedge clk_osc);
        irq_pending = 1'b0;
        chk("R7", "woken", cpu_clk_en, 1);
        chk("R7", "idle bit cleared", pcon_q, 8'h00);
        idle_cycles(3);
        chk("R7", "stays running", cpu_clk_en, 1);
    endtask

    task automatic t_pdown();
        pwrite(8'h13);
        chk("R5", "pd write visible", pcon_q, 8'h13);
        @(negedge clk_osc);
        chk("R8", "pd enables", {cpu_clk_en, per_clk_en, osc_en}, 3'b000);
        irq_pending = 1'b1;
        idle_cycles(6);
        irq_pending = 1'b0;
        chk("R9", "irq ignored", {cpu_clk_en, per_clk_en, osc_en}, 3'b000);
        pwrite(8'h00);
        idle_cycles(2);
        chk("R9", "write ignored", pcon_q, 8'h13);
        chk("R9", "still down", osc_en, 0);
        hold_reset_then_release();
        chk("R4", "bit 4 kept", pcon_q, 8'h10);
        chk("R4", "osc back in reset", osc_en, 1);
        wait_release();
        chk("R9", "reset ends pd", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    endtask

    task automatic t_idle_reset();
        pwrite(8'h11);
        @(negedge clk_osc);
        chk("R6", "idle again", cpu_clk_en, 0);
        hold_reset_then_release();
        chk("R10", "reset from idle", core_rst, 1);
        wait_release();
        chk("R10", "running", cpu_clk_en, 1);
        chk("R10", "mode bits clear", pcon_q, 8'h10);
    endtask

    initial begin
        t_power_up();
        t_glitch();
        t_exact(0);
        t_exact(5);
        t_idle();
        t_pdown();
        t_idle_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule